// File: doc/BRIEF.md
# Bi-phase-mark subframe serializer

This block turns one 32-bit subframe descriptor into 64 unit intervals (UIs) on a single serial line. That is 32 bit cells of two UIs each. The first four cells hold a sync preamble that deliberately breaks the coding rules. The low nibble of the descriptor picks the preamble: B, M or W. Descriptor bits 30 down to 4 go out unchanged as cells 4 to 30. The block computes the final cell, cell 31, as an even-parity bit. Two subframes back to back make one 128-UI frame.

The block runs on the system clock. An external UI strobe `uiTick` advances it by one UI per strobe. Descriptors arrive over a valid/ready handshake. The handshake is open only on the strobe that ends a subframe.

Two faults are reported but not repaired:
- A reserved preamble code, or a set bit 31, gives a one-cycle error pulse. The word is still sent, with a B preamble and with bit 31 cleared.
- A missing descriptor at a subframe boundary gives a one-cycle underrun pulse. The previous subframe is then sent again.

Top module: `bmc_subframe_tx`

## Requirements
- R1: While `rstN` is low, `lineOut`, `descError` and `underrun` are 0. With `uiTick` low, `descReady` is 0.
- R2: `lineOut` changes only in the clock after a cycle with `uiTick` high. A subframe lasts exactly 64 UI strobes.
- R3: The first strobe after reset opens a subframe boundary. After that, every 64th strobe opens one. At the UI after a boundary, `lineOut` starts the preamble for the accepted word's code in bits 3..0. The patterns, listed UI 0 first, are:
  - code 0: B, 11101000
  - code 1: M, 11100010
  - code 2: W, 11100100
- R4: Cells 4 to 30 carry descriptor bits 4 to 30 in bi-phase mark. The line inverts at the start of each cell (even UI). It inverts again at mid-cell (odd UI) only when the bit is 1.
- R5: Cell 31 is coded the same way. Its bit makes the count of ones over cells 4 to 31 even. As a result, the line is low in UI 63 and the next subframe opens with a rising edge.
- R6: `descReady` is high in exactly those clock cycles where `uiTick` is high and the current UI is the last of a subframe, or is the first strobe after reset. A word is accepted when `descValid` is also high in that cycle.
- R7: An accepted word with bits 3..0 above 2, or with bit 31 set, raises `descError` for one clock after the accepting edge. That word is sent with the B preamble, and its parity is computed with bit 31 taken as 0.
- R8: A boundary with `descValid` low raises `underrun` for one clock. The previous cleaned word is then sent again. Before the first accepted word, the previous word is all zeros, which gives a B preamble and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| uiTick | input | 1 | One-cycle strobe per unit interval |
| descValid | input | 1 | Descriptor word offered |
| descData | input | 32 | Descriptor: bit 31 must be 0, bits 30..4 data, bits 3..0 preamble code |
| descReady | output | 1 | Descriptor taken in this cycle if valid |
| lineOut | output | 1 | Bi-phase-mark serial line |
| descError | output | 1 | One-cycle pulse: accepted descriptor was malformed |
| underrun | output | 1 | One-cycle pulse: no descriptor at a boundary |

## Verification
The hardest case to reach is a resend after a malformed word. It needs an error boundary followed at once by an underrun boundary. The resent subframe must then carry the cleaned word: B preamble, bit 31 dropped, and parity recomputed. The stimulus follows a per-subframe plan that holds `descValid` low for chosen subframes, including the very first boundary after reset. It also changes the UI strobe spacing between subframes, so that the line is seen to hold its level across idle clocks.

// File: rtl/bmc_tx_pkg.sv
package bmc_tx_pkg;
  localparam int CELLS   = 32;
  localparam int UIS     = 2 * CELLS;
  localparam int POS_W   = $clog2(UIS);
  localparam int PRE_UIS = 8;
  localparam int CODE_W  = 4;
  localparam int WORD_W  = CELLS;

  localparam logic [PRE_UIS-1:0] PAT_B = 8'b11101000;
  localparam logic [PRE_UIS-1:0] PAT_M = 8'b11100010;
  localparam logic [PRE_UIS-1:0] PAT_W = 8'b11100100;

  localparam logic [CODE_W-1:0] CODE_M    = 4'd1;
  localparam logic [CODE_W-1:0] CODE_W_SF = 4'd2;

  typedef struct packed {
    logic             load;
    logic             take;
    logic             advance;
    logic [POS_W-1:0] pos;
  } bmcStrobe_t;

  function automatic logic codeBad(input logic [CODE_W-1:0] c);
    return c > CODE_W_SF;
  endfunction
endpackage

// File: rtl/bmc_tx_ctrl.sv
module bmc_tx_ctrl
  import bmc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       uiTick,
  input  logic       descValid,
  output logic       descReady,
  output logic       underrun,
  output bmcStrobe_t strobe
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(UIS - 1);

  logic [POS_W-1:0] uiIdx;
  logic [POS_W-1:0] nextPos;
  logic             atLast;

  assign atLast    = (uiIdx == LAST_POS);
  assign nextPos   = atLast ? '0 : uiIdx + 1'b1;
  assign descReady = uiTick && atLast;

  always_comb begin
    strobe.load    = descReady;
    strobe.take    = descReady && descValid;
    strobe.advance = uiTick;
    strobe.pos     = nextPos;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      uiIdx    <= LAST_POS;
      underrun <= 1'b0;
    end else begin
      underrun <= descReady && !descValid;
      if (uiTick) uiIdx <= nextPos;
    end
  end

  AST_READY_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    descReady |=> !descReady); // R6

  AST_UNDERRUN_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> !underrun); // R8
endmodule

// File: rtl/bmc_tx_dpath.sv
module bmc_tx_dpath
  import bmc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bmcStrobe_t        strobe,
  input  logic [WORD_W-1:0] descData,
  output logic              lineOut,
  output logic              descError
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(UIS - 1);
  localparam int               CELL_W   = POS_W - 1;

  logic [WORD_W-1:0]  curWord;
  logic [WORD_W-1:0]  cleaned;
  logic [WORD_W-1:0]  nextWord;
  logic               incomingBad;
  logic [PRE_UIS-1:0] pattern;
  logic               parityBit;
  logic [CELL_W-1:0]  cellIdx;
  logic               cellBit;
  logic [2:0]         preIdx;
  logic               nextLine;

  assign incomingBad = descData[WORD_W-1] || codeBad(descData[CODE_W-1:0]);
  assign cleaned  = {1'b0, descData[WORD_W-2:CODE_W],
                     incomingBad ? {CODE_W{1'b0}} : descData[CODE_W-1:0]};
  assign nextWord = strobe.take ? cleaned : curWord;

  always_comb begin
    case (nextWord[CODE_W-1:0])
      CODE_M:    pattern = PAT_M;
      CODE_W_SF: pattern = PAT_W;
      default:   pattern = PAT_B;
    endcase
  end

  // even parity over data cells 4..30; bit 31 of the stored word is always 0
  assign parityBit = ^nextWord[WORD_W-2:CODE_W];
  assign cellIdx   = strobe.pos[POS_W-1:1];
  assign cellBit   = (cellIdx == CELL_W'(CELLS - 1)) ? parityBit : nextWord[cellIdx];
  assign preIdx    = 3'(PRE_UIS - 1) - strobe.pos[2:0];

  always_comb begin
    if (strobe.pos < POS_W'(PRE_UIS))
      nextLine = pattern[preIdx];
    else if (!strobe.pos[0])
      nextLine = ~lineOut;
    else
      nextLine = lineOut ^ cellBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curWord   <= '0;
      lineOut   <= 1'b0;
      descError <= 1'b0;
    end else begin
      descError <= strobe.take && incomingBad;
      if (strobe.take)   curWord <= cleaned;
      if (strobe.advance) lineOut <= nextLine;
    end
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(lineOut)); // R2

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> lineOut); // R5

  AST_END_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && strobe.pos == LAST_POS) |=> !lineOut); // R5

  AST_ERR_ON_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    descError |-> $past(strobe.take)); // R7
endmodule

// File: rtl/bmc_subframe_tx.sv
module bmc_subframe_tx
  import bmc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        uiTick,
  input  logic        descValid,
  input  logic [31:0] descData,
  output logic        descReady,
  output logic        lineOut,
  output logic        descError,
  output logic        underrun
);
  bmcStrobe_t strobe;

  bmc_tx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .uiTick    (uiTick),
    .descValid (descValid),
    .descReady (descReady),
    .underrun  (underrun),
    .strobe    (strobe)
  );

  bmc_tx_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .descData  (descData),
    .lineOut   (lineOut),
    .descError (descError)
  );
endmodule

// File: tb/tb_bmc_subframe_tx.sv
`timescale 1ns/1ps
module tb_bmc_subframe_tx;
  logic        clk = 1'b0;
  logic        rstN;
  logic        uiTick;
  logic        descValid;
  logic [31:0] descData;
  logic        descReady, lineOut, descError, underrun;

  int compared = 0;
  int mismatched = 0;

  bmc_subframe_tx dut (
    .clk(clk), .rstN(rstN), .uiTick(uiTick), .descValid(descValid),
    .descData(descData), .descReady(descReady), .lineOut(lineOut),
    .descError(descError), .underrun(underrun)
  );

  always #10 clk = ~clk;

  localparam int NPLAN = 12;
  logic [31:0] planWord [NPLAN];
  bit          planValid [NPLAN];

  int          mIdx;
  logic [31:0] mWord;
  logic [0:63] mStream;
  logic        mLine, mErr, mUnd;
  int          sfNum;
  int          cyc;

  task automatic chk(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at sf %0d ui %0d: actual=%0b expected=%0b", tag, sfNum, mIdx, act, exp);
    end
  endtask

  function automatic logic [0:63] buildStream(input logic [31:0] w);
    logic [0:63] s;
    logic [0:7]  pre;
    logic        lvl, b;
    int          ones;
    case (w[3:0])
      4'd1:    pre = 8'b11100010;
      4'd2:    pre = 8'b11100100;
      default: pre = 8'b11101000;
    endcase
    for (int i = 0; i < 8; i++) s[i] = pre[i];
    lvl = 1'b0;
    ones = 0;
    for (int c = 4; c < 32; c++) begin
      if (c < 31) begin b = w[c]; ones += int'(b); end
      else b = (ones % 2 == 1);
      lvl = ~lvl;
      s[2*c] = lvl;
      if (b) lvl = ~lvl;
      s[2*c+1] = lvl;
    end
    return s;
  endfunction

  function automatic string lineTag(input int idx);
    if (idx < 8) return "R3 preamble";
    if (idx < 62) return "R4 data cell";
    return "R5 parity cell";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    planValid[0]  = 0; planWord[0]  = 32'h0;                          // R8 from reset
    planValid[1]  = 1; planWord[1]  = {1'b0, 27'h5A5A5A5, 4'h0};
    planValid[2]  = 1; planWord[2]  = {1'b0, 27'h7FFFFFF, 4'h1};
    planValid[3]  = 1; planWord[3]  = {1'b0, 27'h0000001, 4'h2};
    planValid[4]  = 0; planWord[4]  = 32'hFFFF_FFFF;                  // R8 resend W
    planValid[5]  = 1; planWord[5]  = {1'b0, 27'h1234567, 4'h7};      // R7 reserved
    planValid[6]  = 1; planWord[6]  = {1'b1, 27'h0ABCDEF, 4'h1};      // R7 bit 31
    planValid[7]  = 0; planWord[7]  = {1'b0, 27'h7000000, 4'h2};      // R8 resend cleaned
    planValid[8]  = 1; planWord[8]  = {1'b0, 27'h2AAAAAA, 4'hF};
    planValid[9]  = 1; planWord[9]  = {1'b0, 27'h3C3C3C3, 4'h2};
    planValid[10] = 1; planWord[10] = {1'b0, 27'h0000000, 4'h1};
    planValid[11] = 1; planWord[11] = {1'b0, 27'h4000000, 4'h0};

    rstN = 1'b0; uiTick = 1'b0; descValid = 1'b0; descData = '0;
    mIdx = 63; mWord = '0; mStream = '0; mLine = 0; mErr = 0; mUnd = 0;
    sfNum = 0; cyc = 0;

    repeat (4) begin
      @(negedge clk);
      chk("R1 reset line", lineOut, 1'b0);
      chk("R1 reset error", descError, 1'b0);
      chk("R1 reset underrun", underrun, 1'b0);
      chk("R1 reset ready", descReady, 1'b0);
    end
    rstN = 1'b1;

    while (!(sfNum == NPLAN + 1 && mIdx == 63)) begin
      int per;
      int pi;
      logic [31:0] w;
      if (cyc != 0) @(negedge clk);
      chk(lineTag(mIdx), lineOut, mLine);
      chk("R7 error pulse", descError, mErr);
      chk("R8 underrun pulse", underrun, mUnd);

      pi  = (sfNum < NPLAN) ? sfNum : NPLAN - 1;
      per = (sfNum % 3) + 1;
      uiTick    = (cyc % per == 0);
      descValid = (sfNum < NPLAN) ? planValid[pi] : 1'b1;
      descData  = planWord[pi];
      #1;
      chk("R6 ready", descReady, uiTick && (mIdx == 63));

      mErr = 0; mUnd = 0;
      if (uiTick) begin
        if (mIdx == 63) begin
          if (descValid) begin
            w = descData;
            if (w[31] || w[3:0] > 4'd2) begin mErr = 1; w[3:0] = 4'd0; end
            w[31] = 1'b0;
            mWord = w;
          end else mUnd = 1;
          mStream = buildStream(mWord);
          mIdx = 0;
          sfNum++;
        end else mIdx++;
        mLine = mStream[mIdx];
      end
      cyc++;
    end
    @(negedge clk);
    chk("R5 end low", lineOut, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule